// File: doc/BRIEF.md
# Modulo Reload Timer

This block is a 16-bit up-counter with a small word-addressed register bus. Software picks a clock source and a power-of-two prescaler, loads a start value and an end value, and the counter steps from the start value up to the end value. On the next step it returns to the start value, sets a sticky overflow flag and, if enabled, raises an interrupt line. It is typically used as a periodic or one-shot event source: the counter is stopped, the start and end values are loaded, the counter is reloaded, and counting is started again.

The start and end values are written into holding buffers. They move into the active copies only while counting is stopped, so a running period is never disturbed by a half-finished update. Writing any data to the counter address forces the counter to the active start value.

Top module: `rtmr_top`

## Requirements
- R1: After reset the control word reads 0, the counter reads 0, the end value reads 0xFFFF, the start value reads 0 and `irq_o` is low.
- R2: The clock-select field sits in control bits [4:3]. Only the value 1 (system clock) advances the counter. The values 0, 2 and 3 hold the counter at its present value.
- R3: The prescaler field sits in control bits [2:0]. While running, the counter takes one step every 2^p system clock cycles. The first step lands on the 2^p-th rising edge after the edge that started counting.
- R4: Each step adds 1 to the counter. A step taken while the counter equals the active end value loads the active start value instead of wrapping to zero, so start 0 and end N-1 give a period of N steps.
- R5: The overflow flag (control bit 7) is set by the step that moves the counter from the end value to the start value.
- R6: A write to word address 1 loads the active start value into the counter and ignores the written data. It overrides a step in the same cycle.
- R7: Writes to word address 2 (end value) and word address 3 (start value) go to buffers. A buffer is copied to the active value on every clock edge while clock select is not 1. Reads of these addresses return the active values.
- R8: The flag is cleared by a control write with bit 7 = 0, but only when a control read that returned the flag as 1 has occurred since the last control write. A control write with bit 7 = 1 never sets or clears the flag.
- R9: `irq_o` is high exactly when the flag and the interrupt enable (control bit 6) are both 1.
- R10: When a flag-setting step coincides with a valid clear write, the flag stays set.
- R11: Only the low 16 bits of the start and end values are stored. The upper read bits of addresses 1 to 3 are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus access strobe for this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Word address: 0 control, 1 counter, 2 end value, 3 start value |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as the strobe |
| irq_o | output | 1 | Overflow interrupt |

## Verification
A wrong divider state moves every step to another cycle. This shows up at the counter read after a single prescaled period, and the bench samples on the exact edge count. A stale active start or end value shows up at the first wrap as a wrong reload value or a wrong flag cycle, and reads of addresses 2 and 3 expose it directly. A flag or arming error shows at the control read and at `irq_o` in the cycle after the offending edge. The bench aims one clear write at the exact cycle of a wrap to catch an ordering error there.

// File: rtl/rtmr_pkg.sv
`timescale 1ns/1ps
package rtmr_pkg;
    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_CNT  = 2'd1,
        A_END  = 2'd2,
        A_BEG  = 2'd3
    } rtmr_addr_e;

    localparam logic [1:0] CS_SYS = 2'd1;
endpackage

// File: rtl/rtmr_prescale.sv
`timescale 1ns/1ps
module rtmr_prescale #(
    parameter int PS_W = 3
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            run_i,
    input  logic [PS_W-1:0] ps_i,
    output logic            tick_o
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask   = (DIV_W'(1) << ps_i) - DIV_W'(1);
        tick_o = run_i && ((div_q & mask) == mask);
        div_d  = run_i ? div_q + DIV_W'(1) : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_d;
    end

    // R3
    tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && ps_i != '0) |=> (!tick_o || ps_i != $past(ps_i)));
endmodule

// File: rtl/rtmr_shadow.sv
`timescale 1ns/1ps
module rtmr_shadow #(
    parameter int          W       = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         load_i,
    output logic [W-1:0] act_o
);
    typedef struct packed {
        logic [W-1:0] hold;
        logic [W-1:0] act;
    } shd_t;

    shd_t shd_d, shd_q;

    always_comb begin
        shd_d = shd_q;
        if (wr_i)   shd_d.hold = wdata_i;
        if (load_i) shd_d.act  = shd_q.hold;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) shd_q <= '{hold: RST_VAL, act: RST_VAL};
        else         shd_q <= shd_d;
    end

    assign act_o = shd_q.act;

    // R7
    act_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(act_o));
    // R7
    act_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && $past(wr_i) == 1'b0 && !wr_i) |=> act_o == $past(act_o) || act_o == shd_q.hold);
endmodule

// File: rtl/rtmr_count.sv
`timescale 1ns/1ps
module rtmr_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] beg_i,
    input  logic [CNT_W-1:0] end_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        wrap_o = tick_i && !load_i && (cnt_q == end_i);
        cnt_d  = cnt_q;
        if (load_i)      cnt_d = beg_i;
        else if (wrap_o) cnt_d = beg_i;
        else if (tick_i) cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R6
    force_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> cnt_o == $past(beg_i));
    // R4
    step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !load_i && cnt_o != end_i) |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));
    // R4
    reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !load_i && cnt_o == end_i) |=> cnt_o == $past(beg_i));
endmodule

// File: rtl/rtmr_top.sv
`timescale 1ns/1ps
module rtmr_top #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int PS_W   = 3,
    parameter int CS_W   = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [1:0]        bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    import rtmr_pkg::*;

    localparam int CS_LSB   = PS_W;
    localparam int IE_BIT   = CS_LSB + CS_W + 1;
    localparam int FLAG_BIT = IE_BIT + 1;
    localparam int N_SHD    = 2;

    typedef struct packed {
        logic [PS_W-1:0] ps;
        logic [CS_W-1:0] cs;
        logic            ie;
        logic            flag;
        logic            armed;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic wr_ctrl, rd_ctrl, wr_cnt, run, tick, wrap, unused_wdata;
    logic [N_SHD-1:0] shd_wr;
    logic [CNT_W-1:0] shd_act [N_SHD];
    logic [CNT_W-1:0] cnt;

    always_comb begin
        wr_ctrl   = bus_sel_i && bus_wr_i  && (bus_addr_i == A_CTRL);
        rd_ctrl   = bus_sel_i && !bus_wr_i && (bus_addr_i == A_CTRL);
        wr_cnt    = bus_sel_i && bus_wr_i  && (bus_addr_i == A_CNT);
        shd_wr[0] = bus_sel_i && bus_wr_i  && (bus_addr_i == A_END);
        shd_wr[1] = bus_sel_i && bus_wr_i  && (bus_addr_i == A_BEG);
        run       = (ctrl_q.cs == CS_W'(CS_SYS));
    end

    assign unused_wdata = ^bus_wdata_i;

    rtmr_prescale #(.PS_W(PS_W)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run),
        .ps_i   (ctrl_q.ps),
        .tick_o (tick)
    );

    for (genvar g = 0; g < N_SHD; g++) begin : g_shd
        rtmr_shadow #(
            .W       (CNT_W),
            .RST_VAL ((g == 0) ? {CNT_W{1'b1}} : {CNT_W{1'b0}})
        ) u_shd (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .wr_i    (shd_wr[g]),
            .wdata_i (bus_wdata_i[CNT_W-1:0]),
            .load_i  (!run),
            .act_o   (shd_act[g])
        );
    end

    rtmr_count #(.CNT_W(CNT_W)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick),
        .load_i (wr_cnt),
        .beg_i  (shd_act[1]),
        .end_i  (shd_act[0]),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (rd_ctrl && ctrl_q.flag) ctrl_d.armed = 1'b1;
        if (wr_ctrl) begin
            ctrl_d.ps    = bus_wdata_i[PS_W-1:0];
            ctrl_d.cs    = bus_wdata_i[CS_LSB +: CS_W];
            ctrl_d.ie    = bus_wdata_i[IE_BIT];
            ctrl_d.armed = 1'b0;
            if (ctrl_q.armed && !bus_wdata_i[FLAG_BIT]) ctrl_d.flag = 1'b0;
        end
        if (wrap) ctrl_d.flag = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctrl_q <= '0;
        else         ctrl_q <= ctrl_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_CTRL: begin
                bus_rdata_o[PS_W-1:0]      = ctrl_q.ps;
                bus_rdata_o[CS_LSB +: CS_W] = ctrl_q.cs;
                bus_rdata_o[IE_BIT]        = ctrl_q.ie;
                bus_rdata_o[FLAG_BIT]      = ctrl_q.flag;
            end
            A_CNT:   bus_rdata_o = DATA_W'(cnt);
            A_END:   bus_rdata_o = DATA_W'(shd_act[0]);
            default: bus_rdata_o = DATA_W'(shd_act[1]);
        endcase
    end

    assign irq_o = ctrl_q.flag && ctrl_q.ie;

    // R5
    flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap |=> ctrl_q.flag);
    // R10
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrap && wr_ctrl) |=> irq_o == ctrl_q.ie && ctrl_q.flag);
    // R8
    flag_noset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ctrl_q.flag && !wrap) |=> !ctrl_q.flag);
    // R8
    flag_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_q.flag && !(wr_ctrl && !bus_wdata_i[FLAG_BIT])) |=> ctrl_q.flag);
    // R2
    halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run && !wr_cnt) |=> $stable(cnt));
endmodule

// File: tb/rtmr_top_tb_top.sv
`timescale 1ns/1ps
module rtmr_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rtmr_top dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_sel_i   (sel),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    // start, end, prescaler, irq enable, run cycles
    localparam int unsigned VEC [9][5] = '{
        '{0,      9,      0, 0, 5},
        '{0,      9,      0, 1, 10},
        '{0,      9,      0, 1, 13},
        '{100,    103,    0, 0, 6},
        '{0,      15,     1, 1, 7},
        '{0,      3,      2, 1, 20},
        '{5,      5,      0, 0, 3},
        '{'hFFF0, 'hFFFF, 0, 1, 20},
        '{0,      100,    7, 1, 300}
    };

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #2 d = rdata;
        @(posedge clk);
        #1 sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    function automatic int unsigned model_cnt(int unsigned b, int unsigned e, int unsigned t);
        return b + (t % (e - b + 1));
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        bus_read(0, d); check("R1 ctrl", d, 32'h0);
        bus_read(1, d); check("R1 count", d, 32'h0);
        bus_read(2, d); check("R1 end", d, 32'h0000_FFFF);
        bus_read(3, d); check("R1 start", d, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R3 R4 R5 R9 vector walk
        for (int k = 0; k < 9; k++) begin
            int unsigned b, e, p, ie, cyc, t, t2, fl;
            b = VEC[k][0]; e = VEC[k][1]; p = VEC[k][2]; ie = VEC[k][3]; cyc = VEC[k][4];
            bus_write(0, 32'h0);
            bus_write(3, b);
            bus_write(2, e);
            idle(2);
            bus_write(1, 32'hDEAD_BEEF);
            bus_write(0, p | (1 << 3) | (ie << 6));
            idle(cyc);
            #2;
            t  = cyc >> p;
            fl = (t >= e - b + 1) ? 1 : 0;
            check("R9 irq in vector", {31'b0, irq}, fl & ie);
            bus_read(1, d);
            check("R3/R4 count in vector", d, model_cnt(b, e, t));
            t2 = (cyc + 1) >> p;
            bus_read(0, d);
            check("R5 flag in vector", {31'b0, d[7]}, (t2 >= e - b + 1) ? 1 : 0);
        end
        bus_write(0, 32'h0);

        // R11 upper bits dropped
        bus_write(2, 32'hABCD_1234);
        bus_write(3, 32'hFFFF_0007);
        idle(2);
        bus_read(2, d); check("R11 end width", d, 32'h0000_1234);
        bus_read(3, d); check("R11 start width", d, 32'h0000_0007);

        // R7 buffered while running
        bus_write(1, 32'h0);
        bus_write(0, 32'h08);
        bus_write(2, 32'h20);
        idle(2);
        bus_read(2, d); check("R7 end held while running", d, 32'h1234);
        bus_write(0, 32'h0);
        idle(2);
        bus_read(2, d); check("R7 end copied when stopped", d, 32'h20);

        // R2 other clock selects hold the count
        bus_write(0, 32'h10);
        bus_read(1, d);
        begin
            logic [31:0] held;
            held = d;
            idle(5);
            bus_read(1, d); check("R2 select 2 holds", d, held);
            bus_write(0, 32'h18);
            bus_write(2, 32'h30);
            idle(5);
            bus_read(1, d); check("R2 select 3 holds", d, held);
            bus_read(2, d); check("R7 copy under select 3", d, 32'h30);
        end

        // R6 counter write loads start, data ignored, beats tick
        bus_write(0, 32'h08);
        idle(3);
        bus_write(1, 32'h0000_1234);
        bus_read(1, d); check("R6 forced reload", d, 32'h7);

        // R10 coincident set and clear
        bus_write(0, 32'h0);
        bus_write(3, 32'h0);
        bus_write(2, 32'h3);
        idle(2);
        bus_write(1, 32'h0);
        bus_write(0, 32'h48);
        idle(4);
        bus_read(0, d); check("R5 flag after first wrap", {31'b0, d[7]}, 32'h1);
        check("R9 irq with enable", {31'b0, irq}, 32'h1);
        idle(2);
        bus_write(0, 32'h48);
        bus_read(0, d); check("R10 set beats clear", {31'b0, d[7]}, 32'h1);

        // R8 valid clear
        bus_write(0, 32'h40);
        bus_read(0, d); check("R8 armed clear", {31'b0, d[7]}, 32'h0);
        check("R9 irq low after clear", {31'b0, irq}, 32'h0);

        // R8 clear without prior read is ignored
        bus_write(0, 32'h48);
        idle(8);
        bus_write(0, 32'h40);
        bus_read(0, d); check("R8 unarmed write keeps flag", {31'b0, d[7]}, 32'h1);
        check("R9 irq high", {31'b0, irq}, 32'h1);
        bus_write(0, 32'h80);
        bus_read(0, d); check("R8 write of one keeps flag", {31'b0, d[7]}, 32'h1);
        check("R9 irq masked", {31'b0, irq}, 32'h0);
        bus_write(0, 32'h00);
        bus_read(0, d); check("R8 cleared", {31'b0, d[7]}, 32'h0);
        bus_write(0, 32'h80);
        bus_read(0, d); check("R8 write of one never sets", {31'b0, d[7]}, 32'h0);

        done = 1'b1;
        summary();
    end
endmodule